// File: doc/BRIEF.md
# Scanned-Input Debounce Filter

This block removes contact bounce from a set of inputs that arrive one at a time from an external scanner. Each time the scanner presents a bit, it presents the address of that input and a sample strobe with it. The block then updates the filter state of that one input. A filtered bit takes a new level only after the raw level has disagreed with it for a programmed number of scans. Because the count is in scans and not in clock cycles, the filter time follows the scan rate.

Each input can use either a short time or a long time. The short time is 6 bits and the long time is 10 bits. Both come from fields of the shared control word. A per-input select word picks the long time where its bit is 1 and the short time where its bit is 0. The per-input disagreement counters sit in one small array indexed by the input address, so only one counter is read and rewritten on each strobe. The filtered word is a register, and it shows the result one clock after the strobe.

Top module: `dbf_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, the filtered word is all zeros and every disagreement count is zero.
- R2: When `sel_long[a]` is 0, a strobed sample at address a uses `short_lim` as the threshold T. Bit a of `filt_word` takes the raw level on the (T+1)-th consecutive disagreeing sample of that input, and the change is visible one clock after that strobe.
- R3: When `sel_long[a]` is 1, the same rule applies with `long_lim` as the threshold.
- R4: A strobed sample that equals the current filtered bit clears the count of that input. A disagreement then has to start again from zero.
- R5: With a threshold of 0, the first disagreeing sample changes the filtered bit at the next clock.
- R6: A strobe changes only the bit and the count at its own address. Without a strobe the filtered word does not change, whatever `smp_bit` and `smp_addr` do.
- R7: The threshold and the select bit are taken in the cycle of the strobe. If the threshold is lowered to or below a count already reached, the next disagreeing sample changes the bit.
- R8: The counts of different inputs are independent when the scanner interleaves their samples in any order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe: a raw sample is present this cycle |
| smp_addr | input | AW = clog2(N) | Address of the input being sampled |
| smp_bit | input | 1 | Raw level of the sampled input |
| sel_long | input | N | Per-input select: 1 = long time, 0 = short time |
| short_lim | input | 6 | Short filter time in scans (control field) |
| long_lim | input | 10 | Long filter time in scans (control field) |
| filt_word | output | N | Filtered input word, one bit per input |

## Verification
The hardest case is a threshold change that lands in the same clock as a strobe for an input whose count is already past the new value. The bench builds up a count on the long time. It then lowers `long_lim` in the very cycle of the next disagreeing sample, and expects the bit to change one clock later. A second collision is a bounce sample that agrees with the filtered bit in the cycle where the count would have reached the threshold. Here the model expects the count to clear and no change. A behavioural model tracks every input and is compared with `filt_word` after every clock, across long interleaved scans with random levels and random select words.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    // Field widths of the two filter-time fields in the control word
    localparam int SHORT_W = 6;
    localparam int LONG_W  = 10;
    // Counters must reach the largest threshold
    localparam int CNT_W   = LONG_W;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/dbf_thr_pick.sv
module dbf_thr_pick
    import dbf_pkg::*;
(
    input  logic [SHORT_W-1:0] short_lim,
    input  logic [LONG_W-1:0]  long_lim,
    input  logic               use_long,
    output cnt_t               thr
);
    always_comb begin
        if (use_long) begin
            thr = cnt_t'(long_lim);
        end else begin
            thr = cnt_t'(short_lim);
        end
    end
endmodule

// File: rtl/dbf_step.sv
module dbf_step
    import dbf_pkg::*;
(
    input  logic raw,
    input  logic cur,
    input  cnt_t cnt_cur,
    input  cnt_t thr,
    output cnt_t cnt_nxt,
    output logic take
);
    always_comb begin
        take    = 1'b0;
        cnt_nxt = '0;
        if (raw != cur) begin
            if (cnt_cur >= thr) begin
                take = 1'b1;
            end else begin
                cnt_nxt = cnt_cur + cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/dbf_cnt_ram.sv
module dbf_cnt_ram
    import dbf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output cnt_t          rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  cnt_t          wr_data
);
    cnt_t mem_q [DEPTH];
    cnt_t mem_d [DEPTH];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (AW'(i) == rd_addr) rd_data = mem_q[i];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we && AW'(i) == wr_addr) mem_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/dbf_filter.sv
module dbf_filter
    import dbf_pkg::*;
#(
    parameter int N = 32,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [AW-1:0]      smp_addr,
    input  logic               smp_bit,
    input  logic [N-1:0]       sel_long,
    input  logic [SHORT_W-1:0] short_lim,
    input  logic [LONG_W-1:0]  long_lim,
    output logic [N-1:0]       filt_word
);
    localparam bit FULL_RANGE = (N == (1 << AW));

    typedef struct packed {
        logic [N-1:0] filt;
    } state_t;

    state_t st_d, st_q;
    logic   addr_ok;
    logic   cur_bit;
    logic   cur_sel;
    cnt_t   cnt_rd, cnt_wr, thr;
    logic   take;

    always_comb begin
        if (FULL_RANGE) addr_ok = 1'b1;
        else            addr_ok = (int'(smp_addr) < N);
        cur_bit = 1'b0;
        cur_sel = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (AW'(i) == smp_addr) begin
                cur_bit = st_q.filt[i];
                cur_sel = sel_long[i];
            end
        end
    end

    dbf_thr_pick u_pick (
        .short_lim (short_lim),
        .long_lim  (long_lim),
        .use_long  (cur_sel),
        .thr       (thr)
    );

    dbf_cnt_ram #(.DEPTH(N), .AW(AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (smp_addr),
        .rd_data (cnt_rd),
        .we      (smp_valid && addr_ok),
        .wr_addr (smp_addr),
        .wr_data (cnt_wr)
    );

    dbf_step u_step (
        .raw     (smp_bit),
        .cur     (cur_bit),
        .cnt_cur (cnt_rd),
        .thr     (thr),
        .cnt_nxt (cnt_wr),
        .take    (take)
    );

    always_comb begin
        st_d = st_q;
        if (smp_valid && addr_ok && take) begin
            for (int i = 0; i < N; i++) begin
                if (AW'(i) == smp_addr) st_d.filt[i] = smp_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_word = st_q.filt;
endmodule

// File: rtl/dbf_filter_chk.sv
module dbf_filter_chk
    import dbf_pkg::*;
#(
    parameter int N = 32,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic [AW-1:0]      smp_addr,
    input logic               smp_bit,
    input logic [N-1:0]       sel_long,
    input logic [SHORT_W-1:0] short_lim,
    input logic [LONG_W-1:0]  long_lim,
    input logic [N-1:0]       filt_word
);
    logic zero_thr;
    always_comb begin
        zero_thr = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (AW'(i) == smp_addr)
                zero_thr = sel_long[i] ? (long_lim == '0) : (short_lim == '0);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> filt_word == '0);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(filt_word));

    assert_single_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(filt_word ^ $past(filt_word)) <= 1);

    assert_own_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ((filt_word ^ $past(filt_word)) & ~(N'(1) << $past(smp_addr))) == '0);

    assert_zero_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && zero_thr && smp_bit != filt_word[smp_addr])
        |=> filt_word[$past(smp_addr)] == $past(smp_bit));
endmodule

bind dbf_filter dbf_filter_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_addr  (smp_addr),
    .smp_bit   (smp_bit),
    .sel_long  (sel_long),
    .short_lim (short_lim),
    .long_lim  (long_lim),
    .filt_word (filt_word)
);

// File: tb/sim_dbf_filter.sv
module sim_dbf_filter;
    localparam int N  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [AW-1:0] smp_addr = '0;
    logic          smp_bit = 1'b0;
    logic [N-1:0]  sel_long = '0;
    logic [5:0]    short_lim = 6'd3;
    logic [9:0]    long_lim = 10'd5;
    logic [N-1:0]  filt_word;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";

    int           cnt_m [N];
    logic [N-1:0] filt_m = '0;

    always #5ns clk = ~clk;

    dbf_filter #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_addr(smp_addr),
        .smp_bit(smp_bit), .sel_long(sel_long), .short_lim(short_lim),
        .long_lim(long_lim), .filt_word(filt_word)
    );

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: filt_word=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare after the rising edge
    task automatic tick(input logic v, input int a, input logic b);
        int thr;
        smp_valid = v;
        smp_addr  = AW'(a);
        smp_bit   = b;
        if (v) begin
            thr = sel_long[a] ? int'(long_lim) : int'(short_lim);
            if (b == filt_m[a]) cnt_m[a] = 0;
            else if (cnt_m[a] >= thr) begin
                filt_m[a] = b;
                cnt_m[a]  = 0;
            end else cnt_m[a] = cnt_m[a] + 1;
        end
        @(negedge clk);
        chk(cur_req, filt_word, filt_m);
    endtask

    task automatic bit_chk(input string tag, input int a, input logic exp);
        vectors++;
        if (filt_word[a] !== exp) begin
            errors++;
            $display("FAIL %s: bit %0d got=%b expected=%b", tag, a, filt_word[a], exp);
        end
    endtask

    initial begin
        #2_000_000ns;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) cnt_m[i] = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", filt_word, '0);
        rst_n = 1'b1;
        tick(1'b0, 0, 1'b1);
        chk("R1", filt_word, '0);

        // R2: short time 3 -> change on the 4th disagreeing sample
        cur_req = "R2";
        short_lim = 6'd3;
        for (int k = 0; k < 3; k++) tick(1'b1, 4, 1'b1);
        bit_chk("R2", 4, 1'b0);
        tick(1'b1, 4, 1'b1);
        bit_chk("R2", 4, 1'b1);

        // R3: long time 6 on input 9
        cur_req = "R3";
        sel_long[9] = 1'b1; long_lim = 10'd6; short_lim = 6'd1;
        for (int k = 0; k < 6; k++) tick(1'b1, 9, 1'b1);
        bit_chk("R3", 9, 1'b0);
        tick(1'b1, 9, 1'b1);
        bit_chk("R3", 9, 1'b1);

        // R4: bounce clears the count of input 4 (now high), short time 3
        cur_req = "R4";
        short_lim = 6'd3;
        for (int k = 0; k < 3; k++) tick(1'b1, 4, 1'b0);
        tick(1'b1, 4, 1'b1);          // agrees: count restarts
        for (int k = 0; k < 3; k++) tick(1'b1, 4, 1'b0);
        bit_chk("R4", 4, 1'b1);
        tick(1'b1, 4, 1'b0);
        bit_chk("R4", 4, 1'b0);

        // R5: threshold zero follows at once
        cur_req = "R5";
        short_lim = 6'd0;
        tick(1'b1, 12, 1'b1);
        bit_chk("R5", 12, 1'b1);
        tick(1'b1, 12, 1'b0);
        bit_chk("R5", 12, 1'b0);

        // R6: no strobe, wiggling data and address
        cur_req = "R6";
        for (int k = 0; k < 20; k++) tick(1'b0, k, ~filt_m[k]);
        chk("R6", filt_word, filt_m);
        tick(1'b1, 3, 1'b1);   // only bit 3 may move
        chk("R6", filt_word, filt_m);

        // R7: lower the long time in the same cycle as a sample past the new value
        cur_req = "R7";
        sel_long[20] = 1'b1; long_lim = 10'd8;
        for (int k = 0; k < 5; k++) tick(1'b1, 20, 1'b1);
        bit_chk("R7", 20, 1'b0);
        long_lim = 10'd2;
        tick(1'b1, 20, 1'b1);
        bit_chk("R7", 20, 1'b1);

        // R8: interleaved scans with random levels and selects
        cur_req = "R8";
        short_lim = 6'd2; long_lim = 10'd5;
        for (int s = 0; s < 60; s++) begin
            logic [N-1:0] lvl;
            if (s % 8 == 0) begin
                lvl = N'($urandom);
                sel_long = N'($urandom);
            end
            for (int a = 0; a < N; a++) begin
                logic b;
                b = (($urandom % 10) == 0) ? ~lvl[a] : lvl[a];
                tick(1'b1, a, b);
                if (($urandom % 7) == 0) tick(1'b0, a, 1'b1);
            end
        end
        // random addresses, random limits including zero
        for (int k = 0; k < 3000; k++) begin
            if (k % 200 == 0) begin
                short_lim = 6'($urandom % 4);
                long_lim  = 10'($urandom % 9);
            end
            tick(($urandom % 4) != 0, int'($urandom % N), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule